// File: doc/BRIEF.md
# I2C Master Command and Receive Queue

This block is the queueing front end that sits between the register interface of an I2C master and its bus engine. Software writes command words to one data/command register. Each word becomes one transmit-queue entry, which is either a byte to send or a request to receive one byte. Any entry can also carry a flag that asks the engine to end the transfer with a STOP once that byte is done. The engine takes entries from the head of the transmit queue. Bytes it receives go into a separate receive queue, and software drains that queue by reading the same data register.

The block reports the fill level of each queue. It compares each level with a programmable watermark, and it raises a one-cycle event when a queue overflows or underflows. A transfer abort empties both queues at once.

Top module: `i2c_cmd_queue`

## Requirements
- R1: After reset both levels are 0, `cmd_valid` is low, and the three one-cycle events are low.
- R2: A command word with bit 8 clear queues a write entry. The entry shows `cmd_read`=0 and `cmd_data` = word bits 7:0. The engine sees entries in the order they were written.
- R3: A command word with bit 8 set queues a read request. The request takes one transmit slot, so `tx_level` rises by 1. It shows `cmd_read`=1 and `cmd_data`=0, whatever bits 7:0 held.
- R4: Bit 9 of a command word is carried with that entry and appears on `cmd_stop` while the entry is at the head of the queue.
- R5: Each level counts from 0 to DEPTH. An accepted push together with an accepted pop in the same cycle leaves the level unchanged.
- R6: `tx_empty_evt` is high exactly while `tx_level` <= `tx_thresh`.
- R7: `rx_full_evt` is high exactly while `rx_level` > `rx_thresh`.
- R8: A command written while `tx_level` = DEPTH is dropped, even if the engine pops in the same cycle. The queue contents stay unchanged, and `tx_over_evt` is high for the one cycle after that edge.
- R9: While the receive queue is empty, `rd_data` reads 0. A read strobe in that state raises `rx_under_evt` for the one cycle after that edge.
- R10: A byte pushed by the engine while `rx_level` = DEPTH is dropped, and `rx_over_evt` is high for the one cycle after that edge.
- R11: When `abort` is high, both levels are 0 after the edge. Abort wins over any push in the same cycle.
- R12: `rd_data` shows the oldest received byte, and bytes come out in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write of a command word this cycle |
| wr_data | input | 10 | Command word: bit 9 = stop, bit 8 = read, bits 7:0 = data byte |
| rd_strobe | input | 1 | Read of the data register this cycle (pops the receive queue) |
| rd_data | output | 8 | Oldest received byte, 0 when the queue is empty |
| tx_thresh | input | LW | Transmit watermark |
| rx_thresh | input | LW | Receive watermark |
| abort | input | 1 | Transfer abort, empties both queues |
| cmd_valid | output | 1 | Transmit queue holds at least one entry |
| cmd_ready | input | 1 | Engine takes the head entry |
| cmd_data | output | 8 | Head entry byte (0 for a read request) |
| cmd_read | output | 1 | Head entry is a read request |
| cmd_stop | output | 1 | Head entry asks for STOP afterwards |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| tx_level | output | LW | Transmit queue fill level |
| rx_level | output | LW | Receive queue fill level |
| tx_empty_evt | output | 1 | Transmit level at or below its watermark |
| rx_full_evt | output | 1 | Receive level above its watermark |
| tx_over_evt | output | 1 | One-cycle transmit overflow event |
| rx_under_evt | output | 1 | One-cycle receive underflow event |
| rx_over_evt | output | 1 | One-cycle receive overflow event |

LW is $clog2(DEPTH+1).

## Verification
The bench builds the block with DEPTH=4, so LW is 3 bits. With that depth, both queues reach full after only a few pushes. The tests fill and drain each queue more than once, which takes the read and write pointers around the end of storage. The overflow cases that matter can be reached in a handful of cycles: a write while full, a write while full with a pop in the same cycle, and a push-plus-pop below full. The watermarks are set to 1, so each watermark output changes state between two neighbouring levels.

// File: rtl/i2c_cmdq_pkg.sv
// Shared types and command-word bit positions for the I2C command queue.
package i2c_cmdq_pkg;
    localparam int CMD_RD_BIT   = 8;
    localparam int CMD_STOP_BIT = 9;
    localparam int CMD_W        = 10;

    typedef struct packed {
        logic       stop;
        logic       rd;
        logic [7:0] dat;
    } cmd_entry_t;
endpackage

// File: rtl/cmdq_ring.sv
// Synchronous ring-buffer FIFO with a fill-level counter and a flush input.
// A push is accepted only when the FIFO is not full; a pop only when it is not
// empty. Flush has priority over push and pop. Storage is not reset.
module cmdq_ring #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int LW = $clog2(DEPTH + 1),
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic             do_push, do_pop;

    // Status and acceptance decode
    always_comb begin
        full    = (level == LW'(DEPTH));
        empty   = (level == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
    end

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and level bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= ptr_next(wp);
            if (do_pop)  rp <= ptr_next(rp);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= wdata;
    end

    assign head = mem[rp];
endmodule

// File: rtl/cmdq_flags.sv
// Watermark comparators and one-cycle over/underflow events for both queues.
// Assumes the full/empty inputs describe the state before the current edge.
module cmdq_flags #(
    parameter int DEPTH = 8,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] tx_level,
    input  logic [LW-1:0] rx_level,
    input  logic [LW-1:0] tx_thresh,
    input  logic [LW-1:0] rx_thresh,
    input  logic          tx_full,
    input  logic          rx_full,
    input  logic          rx_empty,
    input  logic          wr_req,
    input  logic          rd_req,
    input  logic          rx_in,
    output logic          tx_low,
    output logic          rx_high,
    output logic          tx_over,
    output logic          rx_under,
    output logic          rx_over
);
    // Level watermark comparison
    always_comb begin
        tx_low  = (tx_level <= tx_thresh);
        rx_high = (rx_level > rx_thresh);
    end

    // Registered error pulses, one cycle after the offending edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_over  <= 1'b0;
            rx_under <= 1'b0;
            rx_over  <= 1'b0;
        end else begin
            tx_over  <= wr_req && tx_full;
            rx_under <= rd_req && rx_empty;
            rx_over  <= rx_in && rx_full;
        end
    end
endmodule

// File: rtl/i2c_cmd_queue.sv
// Command/data queue front end of an I2C master. Command words go into a
// transmit FIFO consumed by the bus engine; received bytes go into a receive
// FIFO read by software. Abort empties both. Assumes one register access per
// cycle on each side.
module i2c_cmd_queue
    import i2c_cmdq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [CMD_W-1:0] wr_data,
    input  logic             rd_strobe,
    output logic [7:0]       rd_data,
    input  logic [LW-1:0]    tx_thresh,
    input  logic [LW-1:0]    rx_thresh,
    input  logic             abort,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [7:0]       cmd_data,
    output logic             cmd_read,
    output logic             cmd_stop,
    input  logic             rx_push,
    input  logic [7:0]       rx_byte,
    output logic [LW-1:0]    tx_level,
    output logic [LW-1:0]    rx_level,
    output logic             tx_empty_evt,
    output logic             rx_full_evt,
    output logic             tx_over_evt,
    output logic             rx_under_evt,
    output logic             rx_over_evt
);
    cmd_entry_t in_ent, head_ent;
    logic       tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0] rx_head;

    // Unpack a command word; read requests drop their data bits
    always_comb begin
        in_ent.stop = wr_data[CMD_STOP_BIT];
        in_ent.rd   = wr_data[CMD_RD_BIT];
        in_ent.dat  = wr_data[CMD_RD_BIT] ? 8'h00 : wr_data[7:0];
    end

    cmdq_ring #(.WIDTH($bits(cmd_entry_t)), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(abort),
        .push(wr_valid), .wdata(in_ent),
        .pop(cmd_ready), .head(head_ent),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    cmdq_ring #(.WIDTH(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(abort),
        .push(rx_push), .wdata(rx_byte),
        .pop(rd_strobe), .head(rx_head),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    cmdq_flags #(.DEPTH(DEPTH)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
        .tx_full(tx_full), .rx_full(rx_full), .rx_empty(rx_empty),
        .wr_req(wr_valid), .rd_req(rd_strobe), .rx_in(rx_push),
        .tx_low(tx_empty_evt), .rx_high(rx_full_evt),
        .tx_over(tx_over_evt), .rx_under(rx_under_evt), .rx_over(rx_over_evt)
    );

    // Head presentation, forced to zero when a queue is empty
    always_comb begin
        cmd_valid = !tx_empty;
        cmd_data  = tx_empty ? 8'h00 : head_ent.dat;
        cmd_read  = !tx_empty && head_ent.rd;
        cmd_stop  = !tx_empty && head_ent.stop;
        rd_data   = rx_empty ? 8'h00 : rx_head;
    end
endmodule

// File: rtl/i2c_cmdq_chk.sv
// Property checker for i2c_cmd_queue, attached by bind below.
module i2c_cmdq_chk #(
    parameter int DEPTH = 8,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          rd_strobe,
    input logic [7:0]    rd_data,
    input logic          abort,
    input logic          cmd_ready,
    input logic          rx_push,
    input logic          cmd_valid,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic          tx_over_evt,
    input logic          rx_under_evt,
    input logic          rx_over_evt
);
    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(tx_level) <= DEPTH) && (int'(rx_level) <= DEPTH));
    // R5
    level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !abort |=> (int'(tx_level) <= int'($past(tx_level)) + 1)
                && (int'(tx_level) + 1 >= int'($past(tx_level))));
    // R8
    tx_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && int'(tx_level) == DEPTH) |=> tx_over_evt);
    // R8
    tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && int'(tx_level) == DEPTH && !cmd_ready && !abort) |=> $stable(tx_level));
    // R9
    rx_under_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && rx_level == '0) |-> (rd_data == 8'h00) ##1 rx_under_evt);
    // R10
    rx_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && int'(rx_level) == DEPTH) |=> rx_over_evt);
    // R11
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (tx_level == '0) && (rx_level == '0) && !cmd_valid);
endmodule

bind i2c_cmd_queue i2c_cmdq_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/i2c_cmd_queue_tb.sv
module i2c_cmd_queue_tb;
    localparam int DEPTH = 4;
    localparam int LW = $clog2(DEPTH + 1);

    logic clk = 0, rst_n = 0;
    logic wr_valid = 0, rd_strobe = 0, abort = 0, cmd_ready = 0, rx_push = 0;
    logic [9:0] wr_data = '0;
    logic [7:0] rx_byte = '0, rd_data, cmd_data;
    logic [LW-1:0] tx_thresh = LW'(1), rx_thresh = LW'(1), tx_level, rx_level;
    logic cmd_valid, cmd_read, cmd_stop;
    logic tx_empty_evt, rx_full_evt, tx_over_evt, rx_under_evt, rx_over_evt;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    i2c_cmd_queue #(.DEPTH(DEPTH)) u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: strobes set by the caller are held across one edge, then cleared
    task automatic tick();
        @(posedge clk); #1;
        wr_valid = 0; rd_strobe = 0; abort = 0; cmd_ready = 0; rx_push = 0;
    endtask

    task automatic put_cmd(input logic [9:0] w);
        wr_valid = 1; wr_data = w; tick();
    endtask

    task automatic take_cmd(input int exp_dat, input int exp_rd, input int exp_stop, input string req);
        chk({req, " cmd_valid"}, cmd_valid, 1);
        chk({req, " cmd_data"}, cmd_data, exp_dat);
        chk({req, " cmd_read"}, cmd_read, exp_rd);
        chk({req, " cmd_stop"}, cmd_stop, exp_stop);
        cmd_ready = 1; tick();
    endtask

    task automatic t_reset();
        chk("R1 tx_level", tx_level, 0);
        chk("R1 rx_level", rx_level, 0);
        chk("R1 cmd_valid", cmd_valid, 0);
        chk("R1 events", {tx_over_evt, rx_under_evt, rx_over_evt}, 0);
        chk("R6 tx_empty_evt at reset", tx_empty_evt, 1);
        chk("R7 rx_full_evt at reset", rx_full_evt, 0);
    endtask

    task automatic t_kinds();
        put_cmd(10'h0A5);
        put_cmd(10'h1FF);
        chk("R3 read takes a slot", tx_level, 2);
        put_cmd(10'h23C);
        take_cmd(8'hA5, 0, 0, "R2 write entry");
        take_cmd(8'h00, 1, 0, "R3 read entry");
        take_cmd(8'h3C, 0, 1, "R4 stop entry");
        chk("R5 drained", tx_level, 0);
        cmd_ready = 1; tick();
        chk("R5 pop on empty ignored", tx_level, 0);
    endtask

    task automatic t_tx_over();
        put_cmd(10'h001);
        chk("R6 level 1 <= thresh", tx_empty_evt, 1);
        put_cmd(10'h002);
        chk("R6 level 2 > thresh", tx_empty_evt, 0);
        put_cmd(10'h003);
        put_cmd(10'h004);
        chk("R5 full level", tx_level, DEPTH);
        put_cmd(10'h0EE);
        chk("R8 overflow event", tx_over_evt, 1);
        chk("R8 level unchanged", tx_level, DEPTH);
        tick();
        chk("R8 event one cycle", tx_over_evt, 0);
        wr_valid = 1; wr_data = 10'h0DD; cmd_ready = 1; tick();
        chk("R8 write at full dropped despite pop", tx_level, DEPTH - 1);
        wr_valid = 1; wr_data = 10'h005; cmd_ready = 1; tick();
        chk("R5 push+pop keeps level", tx_level, DEPTH - 1);
        take_cmd(8'h03, 0, 0, "R8 order after drop");
        take_cmd(8'h04, 0, 0, "R8 order after drop");
        take_cmd(8'h05, 0, 0, "R2 order across wrap");
        chk("R6 empty again", tx_empty_evt, 1);
    endtask

    task automatic t_rx();
        rx_push = 1; rx_byte = 8'h11; tick();
        chk("R7 level 1 not above thresh", rx_full_evt, 0);
        rx_push = 1; rx_byte = 8'h22; tick();
        chk("R7 level 2 above thresh", rx_full_evt, 1);
        rx_push = 1; rx_byte = 8'h33; tick();
        rx_push = 1; rx_byte = 8'h44; tick();
        rx_push = 1; rx_byte = 8'h55; tick();
        chk("R10 overflow event", rx_over_evt, 1);
        chk("R10 level held", rx_level, DEPTH);
        tick();
        chk("R10 event one cycle", rx_over_evt, 0);
        for (int i = 1; i <= 4; i++) begin
            chk("R12 rd_data order", rd_data, 8'h11 * i);
            rd_strobe = 1; tick();
        end
        chk("R7 drained", rx_full_evt, 0);
        chk("R9 empty reads zero", rd_data, 0);
        rd_strobe = 1; tick();
        chk("R9 underflow event", rx_under_evt, 1);
        chk("R9 level stays 0", rx_level, 0);
        tick();
        chk("R9 event one cycle", rx_under_evt, 0);
    endtask

    task automatic t_abort();
        put_cmd(10'h011); put_cmd(10'h122); put_cmd(10'h033);
        rx_push = 1; rx_byte = 8'h77; tick();
        rx_push = 1; rx_byte = 8'h78; tick();
        chk("R11 pre tx", tx_level, 3);
        abort = 1; wr_valid = 1; wr_data = 10'h099; rx_push = 1; tick();
        chk("R11 tx flushed", tx_level, 0);
        chk("R11 rx flushed", rx_level, 0);
        chk("R11 no head", cmd_valid, 0);
        put_cmd(10'h042);
        take_cmd(8'h42, 0, 0, "R11 fresh after abort");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_kinds();
        t_tx_over();
        t_rx();
        t_abort();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule